// File: doc/BRIEF.md
# Wide-Instruction Memory Slot Unit

This unit carries out the memory portion of a wide instruction word, one slot per clock. Each cycle it receives a 4-bit operation code, two 6-bit register numbers (a data register and an index register) and a 12-bit displacement. It sends the two register numbers to the register file's read ports and gets their current values back in the same cycle. Its own adder forms an address from the index value and the sign-extended displacement. It drives a data-memory port that is separate from instruction fetch. One cycle later it issues a register write-back request.

The slot can load a word, store a word, or write to a register without touching memory. In that last case the adder works as a register-plus-constant unit, or an 18-bit constant is built from the index and displacement fields. The register file, instruction fetch and the other slots belong to the surrounding machine. Every write-back, including one for a non-memory operation, appears exactly one cycle after its instruction. This keeps the register file's timing the same for all operations.

Top module: `mem_slot_unit`

## Requirements
- R1: While `rst_n` is low, `mem_rd`, `mem_wr` and `wb_valid` are 0. Asserting reset clears a pending write-back at once, without waiting for a clock edge.
- R2: In every cycle, `mem_addr` equals `rf_xval` plus the 12-bit `ins_disp` sign-extended to 32 bits, modulo 2^32.
- R3: Opcode 1 (load) raises `mem_rd` with `mem_wr` low. In the next cycle, `wb_valid` is 1, `wb_reg` is the load's `ins_dreg`, and `wb_data` is the memory word at the address presented.
- R4: Opcode 2 (store) raises `mem_wr` with `mem_rd` low and drives `mem_wdata` with `rf_dval`. No write-back follows in the next cycle.
- R5: Opcode 3 (load-address) raises neither memory strobe. In the next cycle, `wb_valid` is 1 and `wb_data` is the address computed under R2.
- R6: Opcode 4 (load-constant) raises neither memory strobe. In the next cycle, `wb_valid` is 1 and `wb_data` is `ins_xreg` placed in bits 17:12 and `ins_disp` in bits 11:0, with bits 31:18 zero.
- R7: Opcode 0 and opcodes 5 to 15 raise neither memory strobe and produce no write-back in the next cycle. A memory word they address is left unchanged.
- R8: `rf_xsel` follows `ins_xreg` and `rf_dsel` follows `ins_dreg` in the same cycle.
- R9: Instructions issued in consecutive cycles each produce their own write-back, one cycle after issue. A write-back is not affected by the instruction that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_op | input | 4 | Memory-slot operation code |
| ins_dreg | input | 6 | Data register number |
| ins_xreg | input | 6 | Index register number |
| ins_disp | input | 12 | Displacement, signed |
| rf_xsel | output | 6 | Register file read select, index operand |
| rf_dsel | output | 6 | Register file read select, data operand |
| rf_xval | input | 32 | Index register value |
| rf_dval | input | 32 | Data register value |
| mem_addr | output | 32 | Data memory address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_wdata | output | 32 | Data memory write word |
| mem_rdata | input | 32 | Data memory read word, one cycle after `mem_rd` |
| wb_valid | output | 1 | Write-back request valid |
| wb_reg | output | 6 | Write-back register number |
| wb_data | output | 32 | Write-back value |

## Verification
The hardest case to reach from the ports is a write-back taken while a different kind of instruction is already on the inputs. The returned word must come from the memory port for a load and from the captured value for the other operations, even though the current opcode points the other way. The stimulus table chains stores, loads, load-address and load-constant operations back to back, so each write-back is checked while the next instruction is being issued. It also stores through a wrapped address and reads the word back. The table places an undefined opcode over a stored word, and a later load shows that the word is unchanged.

// File: rtl/mem_slot_unit.sv
module mem_slot_unit #(
  parameter int DATA_W = 32,
  parameter int RSEL_W = 6,
  parameter int DISP_W = 12,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [RSEL_W-1:0] ins_dreg,
  input  logic [RSEL_W-1:0] ins_xreg,
  input  logic [DISP_W-1:0] ins_disp,
  output logic [RSEL_W-1:0] rf_xsel,
  output logic [RSEL_W-1:0] rf_dsel,
  input  logic [DATA_W-1:0] rf_xval,
  input  logic [DATA_W-1:0] rf_dval,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_valid,
  output logic [RSEL_W-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data
);

  localparam int IMM_W = RSEL_W + DISP_W;
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(2);
  localparam logic [OP_W-1:0] OP_LADDR = OP_W'(3);
  localparam logic [OP_W-1:0] OP_LCONS = OP_W'(4);

  logic              is_load, is_store, is_laddr, is_lcons;
  logic [DATA_W-1:0] eff_addr, const_val;
  logic              wb_valid_q, load_q;
  logic [RSEL_W-1:0] wb_reg_q;
  logic [DATA_W-1:0] held_q;

  assign is_load  = (ins_op == OP_LOAD);
  assign is_store = (ins_op == OP_STORE);
  assign is_laddr = (ins_op == OP_LADDR);
  assign is_lcons = (ins_op == OP_LCONS);

  assign rf_xsel = ins_xreg;
  assign rf_dsel = ins_dreg;

  assign eff_addr  = rf_xval + {{(DATA_W-DISP_W){ins_disp[DISP_W-1]}}, ins_disp};
  assign const_val = {{(DATA_W-IMM_W){1'b0}}, ins_xreg, ins_disp};

  assign mem_addr  = eff_addr;
  assign mem_rd    = rst_n & is_load;
  assign mem_wr    = rst_n & is_store;
  assign mem_wdata = rf_dval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      load_q     <= 1'b0;
      wb_reg_q   <= '0;
      held_q     <= '0;
    end else begin
      wb_valid_q <= is_load | is_laddr | is_lcons;
      load_q     <= is_load;
      wb_reg_q   <= ins_dreg;
      held_q     <= is_laddr ? eff_addr : const_val;
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_reg   = wb_reg_q;
  assign wb_data  = load_q ? mem_rdata : held_q;

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_load_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (wb_valid && wb_reg == $past(ins_dreg) && wb_data == mem_rdata));

  assert_store_nowb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !wb_valid);

  assert_laddr_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == OP_LADDR) |=> (wb_valid && wb_data == $past(mem_addr)));

  assert_lcons_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == OP_LCONS) |=>
      (wb_valid && wb_data == {{(DATA_W-IMM_W){1'b0}}, $past(ins_xreg), $past(ins_disp)}));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_op == '0 || ins_op > OP_LCONS) |-> (!mem_rd && !mem_wr) ##1 !wb_valid);

endmodule

// File: tb/mem_slot_unit_bench.sv
module mem_slot_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ins_op = 4'd1;
  logic [5:0]  ins_dreg = '0, ins_xreg = '0;
  logic [11:0] ins_disp = '0;
  logic [5:0]  rf_xsel, rf_dsel;
  logic [31:0] rf_xval = '0, rf_dval = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic        wb_valid;
  logic [5:0]  wb_reg;
  logic [31:0] wb_data;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mem_slot_unit u_mem_slot_unit (
    .clk(clk), .rst_n(rst_n),
    .ins_op(ins_op), .ins_dreg(ins_dreg), .ins_xreg(ins_xreg), .ins_disp(ins_disp),
    .rf_xsel(rf_xsel), .rf_dsel(rf_dsel), .rf_xval(rf_xval), .rf_dval(rf_dval),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  logic [31:0] dmem [256];
  initial begin
    for (int k = 0; k < 256; k++) dmem[k] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_wr) dmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= dmem[mem_addr[7:0]];
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [5:0]  dreg;
    logic [5:0]  xreg;
    logic [11:0] disp;
    logic [31:0] xval;
    logic [31:0] dval;
    logic [31:0] ea;
    logic        wbv;
    logic [31:0] wbd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  6'd5,  6'd3,  12'h010, 32'h0000_0020, 32'hDEAD_BEEF, 32'h0000_0030, 1'b0, 32'h0},
    '{4'd2,  6'd6,  6'd4,  12'hFFC, 32'h0000_0044, 32'h1234_5678, 32'h0000_0040, 1'b0, 32'h0},
    '{4'd1,  6'd7,  6'd3,  12'h010, 32'h0000_0020, 32'h0,         32'h0000_0030, 1'b1, 32'hDEAD_BEEF},
    '{4'd1,  6'd8,  6'd9,  12'h000, 32'h0000_0040, 32'h0,         32'h0000_0040, 1'b1, 32'h1234_5678},
    '{4'd3,  6'd10, 6'd2,  12'h7FF, 32'h0000_1000, 32'h0,         32'h0000_17FF, 1'b1, 32'h0000_17FF},
    '{4'd3,  6'd11, 6'd2,  12'h800, 32'h0000_0100, 32'h0,         32'hFFFF_F900, 1'b1, 32'hFFFF_F900},
    '{4'd4,  6'd12, 6'd63, 12'hFFF, 32'h0000_0000, 32'h0,         32'hFFFF_FFFF, 1'b1, 32'h0003_FFFF},
    '{4'd4,  6'd13, 6'd1,  12'h234, 32'h0000_0005, 32'h0,         32'h0000_0239, 1'b1, 32'h0000_1234},
    '{4'd0,  6'd1,  6'd1,  12'h010, 32'h0000_0020, 32'h0,         32'h0000_0030, 1'b0, 32'h0},
    '{4'd15, 6'd2,  6'd3,  12'h010, 32'h0000_0020, 32'h0BAD_0BAD, 32'h0000_0030, 1'b0, 32'h0},
    '{4'd1,  6'd14, 6'd3,  12'h010, 32'h0000_0020, 32'h0,         32'h0000_0030, 1'b1, 32'hDEAD_BEEF},
    '{4'd2,  6'd1,  6'd1,  12'h040, 32'hFFFF_FFF0, 32'hCAFE_F00D, 32'h0000_0030, 1'b0, 32'h0},
    '{4'd1,  6'd63, 6'd0,  12'h030, 32'h0000_0000, 32'h0,         32'h0000_0030, 1'b1, 32'hCAFE_F00D},
    '{4'd5,  6'd4,  6'd0,  12'h000, 32'h0000_0000, 32'h0,         32'h0000_0000, 1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string wb_tag(input logic [3:0] op);
    case (op)
      4'd1: return "R3 load write-back";
      4'd2: return "R4 store no write-back";
      4'd3: return "R5 load-address write-back";
      4'd4: return "R6 load-constant write-back";
      default: return "R7 idle no write-back";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    ins_op = v.op; ins_dreg = v.dreg; ins_xreg = v.xreg; ins_disp = v.disp;
    rf_xval = v.xval; rf_dval = v.dval;
  endtask

  task automatic check_wb(input vec_t v);
    chk({wb_tag(v.op), " valid"}, 32'(wb_valid), 32'(v.wbv));
    if (v.wbv) begin
      chk({wb_tag(v.op), " reg"}, 32'(wb_reg), 32'(v.dreg));
      chk({wb_tag(v.op), " data"}, wb_data, v.wbd);
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset holds strobes and write-back low even with a load presented
    @(negedge clk);
    #1;
    chk("R1 reset mem_rd", 32'(mem_rd), 32'd0);
    chk("R1 reset mem_wr", 32'(mem_wr), 32'd0);
    chk("R1 reset wb_valid", 32'(wb_valid), 32'd0);
    @(negedge clk);
    chk("R1 reset wb_valid after edge", 32'(wb_valid), 32'd0);
    ins_op = 4'd0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check_wb(TBL[i-1]);
      drive(TBL[i]);
      #1;
      chk("R2 address", mem_addr, TBL[i].ea);
      chk("R3 read strobe", 32'(mem_rd), 32'(TBL[i].op == 4'd1));
      chk("R4 write strobe", 32'(mem_wr), 32'(TBL[i].op == 4'd2));
      if (TBL[i].op == 4'd2) chk("R4 write data", mem_wdata, TBL[i].dval);
      chk("R8 index select", 32'(rf_xsel), 32'(TBL[i].xreg));
      chk("R8 data select", 32'(rf_dsel), 32'(TBL[i].dreg));
    end
    @(negedge clk);
    check_wb(TBL[NV-1]);

    // R9: load then load-address back to back, each write-back in its own cycle
    drive('{4'd1, 6'd20, 6'd0, 12'h040, 32'h0, 32'h0, 32'h40, 1'b1, 32'h1234_5678});
    @(negedge clk);
    drive('{4'd3, 6'd21, 6'd0, 12'h005, 32'h0000_0100, 32'h0, 32'h105, 1'b1, 32'h105});
    #1;
    chk("R9 first wb valid", 32'(wb_valid), 32'd1);
    chk("R9 first wb reg", 32'(wb_reg), 32'd20);
    chk("R9 first wb data", wb_data, 32'h1234_5678);
    @(negedge clk);
    ins_op = 4'd0;
    #1;
    chk("R9 second wb reg", 32'(wb_reg), 32'd21);
    chk("R9 second wb data", wb_data, 32'h0000_0105);

    // R1: asynchronous reset clears a pending write-back
    drive('{4'd4, 6'd30, 6'd1, 12'h001, 32'h0, 32'h0, 32'h1, 1'b1, 32'h1001});
    @(negedge clk);
    chk("R6 pending wb before reset", 32'(wb_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear wb_valid", 32'(wb_valid), 32'd0);
    chk("R1 reset blocks strobe", 32'(mem_rd | mem_wr), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ins_op = 4'd0;
    @(negedge clk);
    chk("R7 idle after reset", 32'(wb_valid), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule